// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block selects the next program counter for a signal-processing core, so that loops run with no branch instructions in their bodies. A loop command names the address of the last instruction in the body. It also picks one of two ways to end the loop: an exit condition, or an iteration count. The sequencer stores the address that follows the command as the loop's first instruction. On every cycle it compares the current PC with the stored last address. On a match it sends the PC back to the first instruction, until the loop is done. Loops nest on a small stack of descriptors.

A second command, single-instruction repeat, runs the instruction that follows it a given number of times. A count of zero means 256 runs. Interrupts are held off while a repeat is running. A taken branch from outside the block drops every pending loop and repeat. All pins are plain control and status lines. No data stream passes through the block, so it has no valid/ready handshake. When a branch is taken, the fetch unit supplies the branch target itself and ignores `next_pc_o` for that cycle.

Top module: `zloop_seq`

## Requirements
- R1: After reset no loop is pending: `loop_active_o`, `irq_inhibit_o` and `loop_ovf_o` are 0 and `next_pc_o` is `pc_i`+1.
- R2: A loop command at PC P records P+1 as the loop start; a match that does not end the loop gives `next_pc_o` = P+1.
- R3: In condition mode (`do_counted_i`=0), a match with `cond_i`=0 restarts the body, and a match with `cond_i`=1 gives `pc_i`+1 and ends the loop.
- R4: In counted mode (`do_counted_i`=1) with count N, the body runs N times: each match lowers the count, and the match at which the count is one ends the loop.
- R5: A loaded count of 0 means 2^CW iterations.
- R6: A repeat command at PC P with count N runs the instruction at P+1 N times (`next_pc_o`=`pc_i` for N-1 cycles); a count of 0 means 256 runs.
- R7: `irq_inhibit_o` is 1 from the cycle after a repeat command through the cycle of its last run, and 0 at all other times.
- R8: Loops nest up to DEPTH levels. Only the innermost end address is compared; when the innermost loop ends, the next loop out resumes.
- R9: A loop command while DEPTH loops are pending is dropped, and `loop_ovf_o` becomes 1 and stays 1 until reset.
- R10: When `branch_i` is 1, `next_pc_o` is `pc_i`+1 and in the next cycle no loop or repeat is pending.
- R11: In a cycle with a loop or repeat command, `next_pc_o` is `pc_i`+1 and no end-address match is taken. If both commands come together, the loop command wins and the repeat command is ignored.
- R12: When there is no match and no repeat is holding, `next_pc_o` is `pc_i`+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_i | input | AW | PC of the instruction executing this cycle |
| do_i | input | 1 | Loop command |
| do_counted_i | input | 1 | 1 = counted loop, 0 = loop until condition |
| do_end_i | input | AW | Address of the last instruction in the loop body |
| do_count_i | input | CW | Iteration count (0 = 2^CW) |
| rpt_i | input | 1 | Single-instruction repeat command |
| rpt_count_i | input | RW | Repeat count (0 = 2^RW) |
| cond_i | input | 1 | Exit condition for condition-mode loops |
| branch_i | input | 1 | An external branch is taken this cycle |
| next_pc_o | output | AW | PC to fetch next |
| loop_active_o | output | 1 | At least one loop is pending |
| irq_inhibit_o | output | 1 | A repeat is running; hold off interrupts |
| loop_ovf_o | output | 1 | Sticky flag: loop stack overflow |

## Verification
A wrong start address or a wrong count appears on `next_pc_o` the first time the PC reaches the end address. A count that is off by one shows up only at loop exit: the body runs one time too many or too few, which moves the exit by a whole body length. A corrupted stack pointer shows up at the pop after the inner loop ends, when the outer loop's end address is compared. A stuck repeat counter shows up on `irq_inhibit_o` and `next_pc_o` within one cycle of the expected last run.

// File: rtl/zl_pkg.sv
package zl_pkg;
  typedef enum logic {
    ZL_UNTIL   = 1'b0,
    ZL_COUNTED = 1'b1
  } zl_mode_e;
endpackage

// File: rtl/zl_stack.sv
module zl_stack
  import zl_pkg::*;
#(
  parameter int AW    = 16,
  parameter int NW    = 17,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic          dec,
  input  logic [AW-1:0] push_start,
  input  logic [AW-1:0] push_end,
  input  logic [NW-1:0] push_cnt,
  input  zl_mode_e      push_mode,
  output logic [AW-1:0] top_start,
  output logic [AW-1:0] top_end,
  output logic [NW-1:0] top_cnt,
  output zl_mode_e      top_mode,
  output logic          empty,
  output logic          full
);
  localparam int PW = $clog2(DEPTH + 1);

  logic [PW-1:0] sp;
  logic [AW-1:0] st_start [DEPTH];
  logic [AW-1:0] st_end   [DEPTH];
  logic [NW-1:0] st_cnt   [DEPTH];
  zl_mode_e      st_mode  [DEPTH];

  assign empty = (sp == '0);
  assign full  = (sp == PW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sp <= '0;
    else if (clr)            sp <= '0;
    else if (push && !full)  sp <= sp + PW'(1);
    else if (pop && !empty)  sp <= sp - PW'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_start[g] <= '0;
        st_end[g]   <= '0;
        st_cnt[g]   <= '0;
        st_mode[g]  <= ZL_UNTIL;
      end else if (push && !full && sp == PW'(g)) begin
        st_start[g] <= push_start;
        st_end[g]   <= push_end;
        st_cnt[g]   <= push_cnt;
        st_mode[g]  <= push_mode;
      end else if (dec && sp == PW'(g + 1)) begin
        st_cnt[g]   <= st_cnt[g] - NW'(1);
      end
    end
  end

  always_comb begin
    top_start = '0;
    top_end   = '0;
    top_cnt   = '0;
    top_mode  = ZL_UNTIL;
    for (int i = 0; i < DEPTH; i++) begin
      if (sp == PW'(i + 1)) begin
        top_start = st_start[i];
        top_end   = st_end[i];
        top_cnt   = st_cnt[i];
        top_mode  = st_mode[i];
      end
    end
  end
endmodule

// File: rtl/zl_repeat.sv
module zl_repeat #(
  parameter int AW = 16,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic          step_en,
  input  logic [RW-1:0] load_cnt,
  input  logic [AW-1:0] load_pc,
  input  logic [AW-1:0] pc,
  output logic          active,
  output logic          hold
);
  localparam int LW = RW + 1;

  logic [LW-1:0] left;
  logic [AW-1:0] rpc;
  logic          at_pc;

  assign at_pc = active && (pc == rpc) && step_en;
  assign hold  = at_pc && (left > LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      left   <= '0;
      rpc    <= '0;
    end else if (clr) begin
      active <= 1'b0;
      left   <= '0;
    end else if (load) begin
      active <= 1'b1;
      left   <= (load_cnt == '0) ? (LW'(1) << RW) : {1'b0, load_cnt};
      rpc    <= load_pc;
    end else if (hold) begin
      left   <= left - LW'(1);
    end else if (at_pc) begin
      active <= 1'b0;
      left   <= '0;
    end
  end
endmodule

// File: rtl/zloop_seq.sv
module zloop_seq
  import zl_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int RW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc_i,
  input  logic          do_i,
  input  logic          do_counted_i,
  input  logic [AW-1:0] do_end_i,
  input  logic [CW-1:0] do_count_i,
  input  logic          rpt_i,
  input  logic [RW-1:0] rpt_count_i,
  input  logic          cond_i,
  input  logic          branch_i,
  output logic [AW-1:0] next_pc_o,
  output logic          loop_active_o,
  output logic          irq_inhibit_o,
  output logic          loop_ovf_o
);
  localparam int NW = CW + 1;

  logic [AW-1:0] pc_inc;
  logic          cmd_do, cmd_rpt, quiet;
  logic          rpt_active, rpt_hold;
  logic [AW-1:0] top_start, top_end;
  logic [NW-1:0] top_cnt, push_cnt;
  zl_mode_e      top_mode, push_mode;
  logic          st_empty, st_full;
  logic          match, leave, pop, dec;

  assign pc_inc    = pc_i + AW'(1);
  assign cmd_do    = do_i && !branch_i;
  assign cmd_rpt   = rpt_i && !do_i && !branch_i;
  assign quiet     = !branch_i && !do_i && !rpt_i;
  assign push_cnt  = (do_count_i == '0) ? (NW'(1) << CW) : {1'b0, do_count_i};
  assign push_mode = do_counted_i ? ZL_COUNTED : ZL_UNTIL;

  zl_stack #(.AW(AW), .NW(NW), .DEPTH(DEPTH)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (branch_i),
    .push       (cmd_do),
    .pop        (pop),
    .dec        (dec),
    .push_start (pc_inc),
    .push_end   (do_end_i),
    .push_cnt   (push_cnt),
    .push_mode  (push_mode),
    .top_start  (top_start),
    .top_end    (top_end),
    .top_cnt    (top_cnt),
    .top_mode   (top_mode),
    .empty      (st_empty),
    .full       (st_full)
  );

  zl_repeat #(.AW(AW), .RW(RW)) u_rpt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (branch_i),
    .load     (cmd_rpt),
    .step_en  (quiet),
    .load_cnt (rpt_count_i),
    .load_pc  (pc_inc),
    .pc       (pc_i),
    .active   (rpt_active),
    .hold     (rpt_hold)
  );

  assign match = quiet && !rpt_hold && !st_empty && (pc_i == top_end);
  assign leave = (top_mode == ZL_COUNTED) ? (top_cnt == NW'(1)) : cond_i;
  assign pop   = match && leave;
  assign dec   = match && !leave && (top_mode == ZL_COUNTED);

  always_comb begin
    if (rpt_hold)            next_pc_o = pc_i;
    else if (match && !leave) next_pc_o = top_start;
    else                     next_pc_o = pc_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  loop_ovf_o <= 1'b0;
    else if (cmd_do && st_full)  loop_ovf_o <= 1'b1;
  end

  assign loop_active_o = !st_empty;
  assign irq_inhibit_o = rpt_active;
endmodule

// File: rtl/zl_chk.sv
module zl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] pc_i,
  input logic          do_i,
  input logic          rpt_i,
  input logic          branch_i,
  input logic [AW-1:0] next_pc_o,
  input logic          loop_active_o,
  input logic          irq_inhibit_o,
  input logic          loop_ovf_o
);
  // R10
  branch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    branch_i |=> (!loop_active_o && !irq_inhibit_o));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_ovf_o |=> loop_ovf_o);

  // R11
  cmd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_i || rpt_i || branch_i) |-> (next_pc_o == pc_i + AW'(1)));

  // R7
  rpt_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_i && !do_i && !branch_i) |=> irq_inhibit_o);

  // R8
  do_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_i && !branch_i) |=> loop_active_o);
endmodule

bind zloop_seq zl_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pc_i          (pc_i),
  .do_i          (do_i),
  .rpt_i         (rpt_i),
  .branch_i      (branch_i),
  .next_pc_o     (next_pc_o),
  .loop_active_o (loop_active_o),
  .irq_inhibit_o (irq_inhibit_o),
  .loop_ovf_o    (loop_ovf_o)
);

// File: tb/sim_zloop_seq.sv
module sim_zloop_seq;
  localparam int AW = 16, CW = 8, RW = 8, DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] pc_i = '0, do_end_i = '0, next_pc_o;
  logic [CW-1:0] do_count_i = '0;
  logic [RW-1:0] rpt_count_i = '0;
  logic do_i = 0, do_counted_i = 0, rpt_i = 0, cond_i = 0, branch_i = 0;
  logic loop_active_o, irq_inhibit_o, loop_ovf_o;

  zloop_seq #(.AW(AW), .CW(CW), .RW(RW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .do_i(do_i), .do_counted_i(do_counted_i),
    .do_end_i(do_end_i), .do_count_i(do_count_i), .rpt_i(rpt_i), .rpt_count_i(rpt_count_i),
    .cond_i(cond_i), .branch_i(branch_i), .next_pc_o(next_pc_o),
    .loop_active_o(loop_active_o), .irq_inhibit_o(irq_inhibit_o), .loop_ovf_o(loop_ovf_o));

  int n_chk = 0, n_fail = 0;
  string tag = "R1";
  int q_start[$], q_end[$], q_cnt[$];
  bit q_cntd[$];
  bit m_rpt = 0, m_ovf = 0;
  int m_left = 0, m_rpc = 0;
  int pc = 0, e_next = 0, act_next = 0, holds = 0, n = 0;

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit d, bit dc, int de, int dn, bit r, int rn, bit c, bit b);
    int top;
    bit quiet, hold, match, ex;
    pc_i = pc[AW-1:0]; do_i = d; do_counted_i = dc; do_end_i = de[AW-1:0];
    do_count_i = dn[CW-1:0]; rpt_i = r; rpt_count_i = rn[RW-1:0]; cond_i = c; branch_i = b;
    quiet = !b && !d && !r;
    top = q_end.size() - 1;
    hold = quiet && m_rpt && pc == m_rpc && m_left > 1;
    match = quiet && !hold && top >= 0 && pc == q_end[top];
    ex = match && (q_cntd[top] ? q_cnt[top] == 1 : c);
    e_next = hold ? pc : (match && !ex) ? q_start[top] : (pc + 1) % (1 << AW);
    #1;
    act_next = int'(next_pc_o);
    check(tag, "next_pc", act_next, e_next);
    check(tag, "loop_active", int'(loop_active_o), int'(top >= 0));
    check(tag, "irq_inhibit", int'(irq_inhibit_o), int'(m_rpt));
    check(tag, "loop_ovf", int'(loop_ovf_o), int'(m_ovf));
    if (hold) holds++;
    @(posedge clk);
    if (b) begin
      q_start.delete(); q_end.delete(); q_cnt.delete(); q_cntd.delete();
      m_rpt = 0;
    end else if (d) begin
      if (q_end.size() == DEPTH) m_ovf = 1;
      else begin
        q_start.push_back(pc + 1); q_end.push_back(de);
        q_cnt.push_back(dn == 0 ? (1 << CW) : dn); q_cntd.push_back(dc);
      end
    end else if (r) begin
      m_rpt = 1; m_left = (rn == 0) ? 256 : rn; m_rpc = pc + 1;
    end else if (hold) begin
      m_left--;
    end else begin
      if (m_rpt && pc == m_rpc) m_rpt = 0;
      if (match) begin
        if (ex) begin
          void'(q_start.pop_back()); void'(q_end.pop_back());
          void'(q_cnt.pop_back()); void'(q_cntd.pop_back());
        end else if (q_cntd[top]) q_cnt[top] = q_cnt[top] - 1;
      end
    end
    @(negedge clk);
    pc = e_next;
  endtask

  task automatic idle(bit c);
    step(0, 0, 0, 0, 0, 0, c, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; idle(0);
    tag = "R12"; repeat (3) idle(1);

    // R4: counted loop, three passes over a three-instruction body
    pc = 10; tag = "R4"; step(1, 1, 13, 3, 0, 0, 0, 0);
    n = 0; while (pc != 14 && n < 100) begin idle(0); n++; end
    check("R4", "body cycles", n, 9);

    // R2: start address is command PC + 1
    pc = 40; tag = "R2"; step(1, 1, 43, 2, 0, 0, 0, 0);
    repeat (3) idle(0);
    check("R2", "restart pc", act_next, 41);
    n = 0; while (pc != 44 && n < 100) begin idle(0); n++; end

    // R3: condition loop, condition rises on the fourth pass
    pc = 50; tag = "R3"; step(1, 0, 52, 0, 0, 0, 0, 0);
    n = 0; while (pc != 53 && n < 100) begin idle(n >= 7); n++; end
    check("R3", "cond loop cycles", n, 8);
    check("R3", "loop released", int'(loop_active_o), 0);

    // R5: zero count gives 2^CW runs
    pc = 60; tag = "R5"; step(1, 1, 61, 0, 0, 0, 0, 0);
    n = 0; while (pc != 62 && n < 1000) begin idle(0); n++; end
    check("R5", "zero-count iterations", n, 1 << CW);

    // R6, R7: repeat five times, then zero count
    pc = 70; tag = "R7"; holds = 0; step(0, 0, 0, 0, 1, 5, 0, 0);
    n = 0; while (pc != 72 && n < 1000) begin idle(0); n++; end
    check("R6", "repeat holds", holds, 4);
    check("R7", "inhibit released", int'(irq_inhibit_o), 0);
    pc = 80; tag = "R6"; holds = 0; step(0, 0, 0, 0, 1, 0, 0, 0);
    n = 0; while (pc != 82 && n < 1000) begin idle(0); n++; end
    check("R6", "zero-count repeat holds", holds, 255);

    // R11: loop and repeat together, loop wins
    pc = 90; tag = "R11"; step(1, 1, 91, 1, 1, 3, 0, 0);
    check("R11", "repeat ignored", int'(irq_inhibit_o), 0);
    n = 0; while (pc != 92 && n < 100) begin idle(0); n++; end
    check("R11", "single pass", n, 1);

    // R8: nested counted loops
    pc = 100; tag = "R8"; step(1, 1, 110, 2, 0, 0, 0, 0);
    n = 0;
    while (pc != 111 && n < 200) begin
      if (pc == 101) step(1, 1, 105, 2, 0, 0, 0, 0); else idle(0);
      n++;
    end
    check("R8", "nested cycles", n, 28);
    check("R8", "all loops done", int'(loop_active_o), 0);

    // R9: overflow on fifth push
    pc = 200; tag = "R9";
    for (int k = 0; k < 5; k++) step(1, 1, 230 - k, 1, 0, 0, 0, 0);
    check("R9", "overflow flag", int'(loop_ovf_o), 1);

    // R10: branch clears loops, then a repeat in progress
    tag = "R10"; step(0, 0, 0, 0, 0, 0, 0, 1);
    check("R10", "loops cleared", int'(loop_active_o), 0);
    check("R9", "overflow held", int'(loop_ovf_o), 1);
    pc = 300; step(0, 0, 0, 0, 1, 9, 0, 0);
    idle(0);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    check("R10", "repeat cleared", int'(irq_inhibit_o), 0);
    check("R10", "branch step pc", act_next, 302);

    summary();
    $finish;
  end
endmodule